// File: doc/BRIEF.md
# Serial PHY Management Frame Master

This block issues management frames to external PHY devices over a two-wire serial link: a clock line (MDC) produced here and a shared bidirectional data line (MDIO) presented as a separate output, output enable and input. Software controls it through a single 32-bit frame register. Writing that register starts a frame. The block sends a run of 32 one bits, then shifts the register out most significant bit first. While it shifts, the register also serves as the shift register, so its readback is scrambled. When the frame ends the register holds its original contents again, and a one-cycle interrupt pulse is raised.

The register layout follows the frame on the wire: bits 31:30 start pattern, 29:28 opcode, 27:23 PHY address, 22:18 register address, 17:16 turnaround, 15:0 data. Opcode bit 29 selects the frame type. When it is 1 the frame is read-like: the master releases the data line for the second turnaround bit and the sixteen data bits, and it captures the PHY's reply into bits 15:0. MDC runs only during a frame. It is the system clock divided by a fixed parameter.

Top module: `mdio_frame_master`

## Requirements
- R1: After reset, busy, irq, mdc and mdio_oe are low and reg_rdata is zero.
- R2: A cycle with reg_wr high loads reg_wdata into the frame register and starts a frame. busy is high from the next cycle until the frame ends.
- R3: MDC is low while idle. During a frame it toggles every CLK_DIV system clocks, so each bit period is 2*CLK_DIV clocks and a frame has exactly 64 rising edges.
- R4: During bit periods 0 to 31 the master sends a 1. During periods 32 to 63 it sends register bits 31 down to 0, start and turnaround fields exactly as written, even if they are not 01 and 10. mdio_o changes only when MDC falls or a frame starts.
- R5: Opcodes 10 and 11 (bit 29 = 1) give read-like frames. Opcodes 00 and 01 give write-like frames.
- R6: In a read-like frame mdio_oe is low for bit periods 47 to 63 and high before them. In a write-like frame mdio_oe is high for all 64 periods. mdio_oe is low when idle.
- R7: In a read-like frame, mdio_i is sampled at the rising MDC edge of periods 48 to 63. Those 16 samples, first received as most significant, end up in bits 15:0, and bits 31:16 return to their written values.
- R8: After a write-like frame, reg_rdata equals the written value exactly. mdio_i has no effect on it.
- R9: busy falls and irq pulses high for exactly one cycle 128*CLK_DIV clocks after the clock edge that accepted the write.
- R10: A write while a frame is active is not blocked. It abandons the frame in progress and starts a full new frame from the preamble with the new value, and only that frame raises irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the frame register |
| reg_wdata | input | 32 | Value written to the frame register |
| reg_rdata | output | 32 | Current frame register contents |
| busy | output | 1 | Frame in progress |
| irq | output | 1 | One-cycle completion pulse |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line value driven by the master |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line value seen at the pin |

## Verification
The hardest case to reach is the reply capture. The input must be valid at the exact system clock edge where MDC rises, and only while the line is released. The bench meets this with a PHY model that watches MDC rises on the ports and, after each rise, presents the data bit for the next period. The model also drives patterns during write-like frames, to show they are ignored. The abandoned-frame case is reached by overwriting the register 180 clocks into a read-like frame. At that point the turnaround is close and MDC may be high. The bench then checks that the new frame runs whole from its preamble and raises a single completion pulse.

// File: rtl/mdio_frame_master.sv
module mdio_frame_master #(
  parameter int CLK_DIV  = 2,
  parameter int PRE_BITS = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        busy,
  output logic        irq,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int STEPS = PRE_BITS + 32;
  localparam int SW    = $clog2(STEPS);
  localparam int DW    = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [SW-1:0] S_PRE  = SW'(PRE_BITS);
  localparam logic [SW-1:0] S_TA2  = SW'(PRE_BITS + 15);
  localparam logic [SW-1:0] S_DAT  = SW'(PRE_BITS + 16);
  localparam logic [SW-1:0] S_LAST = SW'(STEPS - 1);
  localparam logic [DW-1:0] C_LAST = DW'(CLK_DIV - 1);

  logic [31:0]   shreg;
  logic [SW-1:0] step;
  logic [DW-1:0] cnt;
  logic          busy_q, mdc_q, rd_q, rx_q, irq_q;
  logic          tick;

  assign tick = busy_q && (cnt == C_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg  <= '0;
      step   <= '0;
      cnt    <= '0;
      busy_q <= 1'b0;
      mdc_q  <= 1'b0;
      rd_q   <= 1'b0;
      rx_q   <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (reg_wr) begin
        shreg  <= reg_wdata;
        rd_q   <= reg_wdata[29];
        busy_q <= 1'b1;
        step   <= '0;
        cnt    <= '0;
        mdc_q  <= 1'b0;
      end else if (tick) begin
        cnt   <= '0;
        mdc_q <= ~mdc_q;
        if (!mdc_q) begin
          rx_q <= mdio_i;
        end else begin
          if (step >= S_PRE)
            shreg <= {shreg[30:0], (rd_q && step >= S_DAT) ? rx_q : shreg[31]};
          if (step == S_LAST) begin
            busy_q <= 1'b0;
            irq_q  <= 1'b1;
          end else begin
            step <= step + 1'b1;
          end
        end
      end else if (busy_q) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign reg_rdata = shreg;
  assign busy      = busy_q;
  assign irq       = irq_q;
  assign mdc       = mdc_q;
  assign mdio_o    = !busy_q || (step < S_PRE) || shreg[31];
  assign mdio_oe   = busy_q && !(rd_q && step >= S_TA2);
endmodule

// File: rtl/mdio_frame_master_chk.sv
module mdio_frame_master_chk (
  input logic clk,
  input logic rst_n,
  input logic reg_wr,
  input logic busy,
  input logic irq,
  input logic mdc,
  input logic mdio_o,
  input logic mdio_oe
);
  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> busy);

  p_mdc_idle_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  p_mdio_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(reg_wr) && !$fell(mdc)) |-> $stable(mdio_o));

  p_idle_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);

  p_irq_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  p_irq_at_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (!busy && $past(busy)));
endmodule

bind mdio_frame_master mdio_frame_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .busy(busy), .irq(irq),
  .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/test_mdio_frame_master.sv
`timescale 1ns/1ps
module test_mdio_frame_master;
  localparam int D = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        busy, irq, mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0, errors = 0;

  logic [31:0] exp_w;
  logic        exp_rd;
  logic [15:0] rx_pat;
  logic        track = 1'b0, prev_mdc = 1'b0;
  int rise_n, cyc, irq_n, irq_cyc, bit_err, per_err, busy_err, last_rise;

  always #2 clk = ~clk;

  mdio_frame_master #(.CLK_DIV(D)) i_mdio_frame_master (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .busy(busy), .irq(irq), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // PHY model and pin monitor
  always @(posedge clk) begin
    #1;
    if (track) begin
      cyc++;
      if (irq) begin irq_n++; irq_cyc = cyc; end
      if (cyc <= 128*D && !busy) busy_err++;
      if (mdc && !prev_mdc) begin
        if (rise_n < 64) begin
          logic eoe, ebit;
          eoe  = !(exp_rd && rise_n >= 47);
          ebit = (rise_n < 32) ? 1'b1 : exp_w[63-rise_n];
          if (mdio_oe !== eoe || (eoe && mdio_o !== ebit)) bit_err++;
        end
        if (rise_n > 0 && (cyc - last_rise) != 2*D) per_err++;
        last_rise = cyc;
        rise_n++;
        mdio_i = (rise_n >= 48 && rise_n < 64) ? rx_pat[63-rise_n] : rise_n[0];
      end
      prev_mdc = mdc;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic start_frame(input logic [31:0] w, input logic [15:0] rx);
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = w;
    exp_w = w; exp_rd = w[29]; rx_pat = rx;
    rise_n = 0; cyc = 0; irq_n = 0; irq_cyc = 0;
    bit_err = 0; per_err = 0; busy_err = 0; last_rise = 0;
    prev_mdc = 1'b0; mdio_i = 1'b1; track = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic finish_frame(input string tag);
    logic [31:0] exp_r;
    for (int i = 0; i < 128*D + 40 && irq_n == 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    exp_r = exp_rd ? {exp_w[31:16], rx_pat} : exp_w;
    chk(bit_err == 0, {"R4/R6 serial bits ", tag}, bit_err, 0);
    chk(rise_n == 64 && per_err == 0, {"R3 mdc edges ", tag}, rise_n, 64);
    chk(irq_n == 1 && irq_cyc == 128*D + 1, {"R9 irq timing ", tag}, irq_cyc, 128*D + 1);
    chk(busy_err == 0 && !busy, {"R2 busy window ", tag}, busy_err, 0);
    chk(!mdio_oe && !mdc, {"R6 idle release ", tag}, {mdio_oe, mdc}, 0);
    if (exp_rd) chk(reg_rdata === exp_r, {"R5/R7 read capture ", tag}, reg_rdata, exp_r);
    else        chk(reg_rdata === exp_r, {"R5/R8 write restore ", tag}, reg_rdata, exp_r);
    track = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] w;
    logic [15:0] rx;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !irq && !mdc && !mdio_oe && reg_rdata == 0, "R1 reset state",
        {busy, irq, mdc, mdio_oe}, 0);

    // sweep all opcodes over several address/data patterns
    for (int op = 0; op < 4; op++) begin
      for (int p = 0; p < 4; p++) begin
        w  = {2'b01, 2'(op), 5'(p*7 + 1), 5'(31 - p*5), 2'b10, 16'(16'hA5C3 ^ (p * 16'h1111))};
        rx = 16'(16'h3C5A + p * 16'h0F0F + op);
        start_frame(w, rx);
        finish_frame($sformatf("op%0d p%0d", op, p));
      end
    end

    // R4: non-compliant start/turnaround still sent as written
    start_frame({2'b11, 2'b10, 5'd31, 5'd0, 2'b00, 16'hFFFF}, 16'h8001);
    finish_frame("noncompliant read");
    start_frame({2'b00, 2'b01, 5'd0, 5'd31, 2'b01, 16'h0000}, 16'hFFFF);
    finish_frame("noncompliant write");

    // R10: overwrite during an active read-like frame
    start_frame({2'b01, 2'b10, 5'd3, 5'd9, 2'b10, 16'h1234}, 16'hBEEF);
    repeat (180) @(negedge clk);
    chk(busy, "R10 busy before overwrite", busy, 1);
    start_frame({2'b01, 2'b01, 5'd12, 5'd17, 2'b10, 16'hC0DE}, 16'h5555);
    finish_frame("R10 restart");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule